// File: doc/BRIEF.md
# Generation-Bit Event Queue Reader

This block drains a circular queue of interrupt events kept in a small on-chip slot array. Each slot holds one 32-bit word. The most significant bit is a generation marker, and the lower 31 bits carry an interrupt number. The reader does not compare head and tail pointers. It tracks its own slot index and an expected-generation flag, and it treats a slot as holding a fresh event only when the slot's marker differs from that flag. Each time the reader's index passes the last slot, the flag inverts. The producer does the same thing on its own side, so stale words from the previous lap read as empty.

The consumer can issue two kinds of request. A take returns the next event and moves past it. A peek returns the same value but changes no state. The answer is zero when nothing new is waiting, because interrupt number 0 is reserved to mean "nothing found". The result is registered and appears one cycle after the request, together with a one-cycle done strobe. A minimal producer port is included so that a bench can fill the queue. It writes each word with the producer's current generation marker. The first lap is written with the marker set.

Top module: `evq_gen_reader`

## Requirements
- R1: After reset, every slot is cleared, the read index is 0 and the expected-generation flag is 0. A peek issued right after reset therefore returns 0, and `res_done`/`res_data` are both 0.
- R2: A slot holds a new event only when its bit 31 differs from the reader's flag. Otherwise the request returns 0, and neither the index nor the flag changes.
- R3: A take that finds a new event advances the read index by one, modulo the slot count.
- R4: When a take moves the index from the last slot back to slot 0, the reader's flag inverts. Words left from the previous lap then read as empty.
- R5: The returned value is the slot word with bit 31 forced to 0. All 31 number bits are returned unchanged, including the all-ones number.
- R6: A peek returns exactly what a take would return, and it leaves the index and the flag unchanged.
- R7: A request is accepted only while no result is pending. Its result and a single-cycle `res_done` pulse appear on the next clock edge. A request presented in the cycle while `res_done` is high is ignored.
- R8: If `req_take` and `req_peek` are both high, the request is handled as a take.
- R9: Each `prod_wr` stores `{generation, prod_num}` at the producer's index and then advances that index. The producer's generation starts at 1 and inverts each time its index wraps.
- R10: When a write and a read address the same slot in the same cycle, the read sees the slot's previous contents. The new word is visible to later requests.
- R11: A take that finds a new event whose number is 0 returns 0 but still advances past that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prod_wr | input | 1 | Producer write strobe |
| prod_num | input | 31 | Interrupt number to enqueue |
| req_take | input | 1 | Request: return next event and advance |
| req_peek | input | 1 | Request: return next event without advancing |
| res_data | output | 32 | Result: event number with bit 31 clear, or 0 when empty |
| res_done | output | 1 | One-cycle strobe marking a valid result |

## Verification
The interaction of interest is a producer write that lands in the very slot the reader samples on the same clock edge. The bench provokes this directly: it raises `prod_wr` and a take together while the queue is empty. It expects a zero result, and then expects the event from the following take. Random runs also overlap writes with takes and peeks at arbitrary fill levels. A bench model orders each read before its concurrent write, and every answer is compared against that model. A second overlap case holds a take high across the pending cycle and then checks, through a later peek, that the index moved only once.

// File: rtl/evq_pkg.sv
package evq_pkg;

  // Kind of request the consumer port can accept.
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_PEEK = 2'd1,
    REQ_TAKE = 2'd2
  } evq_req_e;

  // Decode the two request pins into one kind; take has priority.
  function automatic evq_req_e evq_decode(input logic take, input logic peek);
    if (take)      return REQ_TAKE;
    else if (peek) return REQ_PEEK;
    else           return REQ_NONE;
  endfunction

endpackage

// File: rtl/evq_rst_sync.sv
module evq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  // Assert asynchronously, release after STAGES clean edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/evq_slot_ram.sv
module evq_slot_ram #(
  parameter int SLOTS  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot_q [SLOTS];

  // One register per slot; all clear on reset so the queue starts empty.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit_w;
    assign hit_w = wr_en && (wr_addr == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q[s] <= '0;
      else if (hit_w) slot_q[s] <= wr_data;
    end
  end

  // Read returns the contents held before any write on this edge (R10).
  assign rd_data = slot_q[rd_addr];

  // R10: a written slot holds the written word on the next cycle.
  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (slot_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/evq_producer.sv
module evq_producer #(
  parameter int SLOTS  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int NUM_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put,
  input  logic [NUM_W-1:0]  put_num,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  logic [IDX_W-1:0] widx_q, widx_d;
  logic             gen_q, gen_d;

  always_comb begin
    widx_d = widx_q;
    gen_d  = gen_q;
    if (put) begin
      widx_d = widx_q + IDX_W'(1);
      if (widx_q == LAST) gen_d = ~gen_q;
    end
  end

  // First lap is written with the generation marker set (R9).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_q <= '0;
      gen_q  <= 1'b1;
    end else if (put) begin
      widx_q <= widx_d;
      gen_q  <= gen_d;
    end
  end

  assign wr_en   = put;
  assign wr_addr = widx_q;
  assign wr_data = {gen_q, put_num};

  // R9: generation inverts exactly when the write index wraps.
  p_gen_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (put && widx_q == LAST) |=> (gen_q != $past(gen_q)) && (widx_q == '0));

  p_gen_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (put && widx_q != LAST) |=> $stable(gen_q));

endmodule

// File: rtl/evq_consumer.sv
module evq_consumer
  import evq_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int NUM_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              peek,
  input  logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] res_data,
  output logic              res_done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  evq_req_e          kind;
  logic              go;
  logic              fresh;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              tog_q, tog_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              done_q, done_d;

  assign kind  = evq_decode(take, peek);
  // A pending result blocks acceptance for one cycle (R7).
  assign go    = (kind != REQ_NONE) && !done_q;
  // Slot is new only when its marker differs from the expected flag (R2).
  assign fresh = (rd_data[DATA_W-1] != tog_q);

  always_comb begin
    idx_d  = idx_q;
    tog_d  = tog_q;
    res_d  = res_q;
    done_d = go;
    if (go) begin
      res_d = fresh ? {1'b0, rd_data[NUM_W-1:0]} : '0;
      if ((kind == REQ_TAKE) && fresh) begin
        idx_d = idx_q + IDX_W'(1);
        if (idx_q == LAST) tog_d = ~tog_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      tog_q <= 1'b0;
    end else if (go) begin
      idx_q <= idx_d;
      tog_q <= tog_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (go) res_q <= res_d;
    end
  end

  assign rd_addr  = idx_q;
  assign res_data = res_q;
  assign res_done = done_q;

  // R7: done is a single-cycle pulse following an accepted request.
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> res_done);

  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && (take || peek)) |=> (!res_done && $stable(idx_q)));

  // R2: an empty slot yields zero and leaves position untouched.
  p_empty_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !fresh) |=> (res_data == '0) && $stable(idx_q) && $stable(tog_q));

  // R3: a successful take moves one slot forward.
  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && take && fresh) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

  // R4: passing the last slot inverts the flag.
  p_tog_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && take && fresh && idx_q == LAST) |=> (tog_q != $past(tog_q)));

  // R5: returned word never carries the marker bit.
  p_top_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> !res_data[DATA_W-1]);

  // R6: a peek changes neither index nor flag.
  p_peek_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !take) |=> $stable(idx_q) && $stable(tog_q));

endmodule

// File: rtl/evq_gen_reader.sv
module evq_gen_reader #(
  parameter int SLOTS  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int NUM_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prod_wr,
  input  logic [NUM_W-1:0]  prod_num,
  input  logic              req_take,
  input  logic              req_peek,
  output logic [DATA_W-1:0] res_data,
  output logic              res_done
);

  logic              rst_n_int;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [IDX_W-1:0]  rd_addr;
  logic [DATA_W-1:0] rd_data;

  evq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  evq_producer #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_prod (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .put     (prod_wr),
    .put_num (prod_num),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  evq_slot_ram #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  evq_consumer #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_cons (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .take     (req_take),
    .peek     (req_peek),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .res_data (res_data),
    .res_done (res_done)
  );

endmodule

// File: tb/tb_evq_gen_reader.sv
module tb_evq_gen_reader;

  localparam int SLOTS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prod_wr = 1'b0;
  logic [30:0] prod_num = '0;
  logic        req_take = 1'b0;
  logic        req_peek = 1'b0;
  logic [31:0] res_data;
  logic        res_done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Bench model of the queue, built from the requirements.
  logic [31:0] mmem [SLOTS];
  int          pidx = 0;
  bit          pgen = 1'b1;
  int          cidx = 0;
  bit          ctog = 1'b0;
  int          mcount = 0;

  always #5 clk = ~clk;

  evq_gen_reader #(.SLOTS(SLOTS)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .prod_wr  (prod_wr),
    .prod_num (prod_num),
    .req_take (req_take),
    .req_peek (req_peek),
    .res_data (res_data),
    .res_done (res_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected answer for a read of the model at the current reader position.
  function automatic logic [31:0] model_answer();
    logic [31:0] e;
    e = mmem[cidx];
    return (e[31] != ctog) ? {1'b0, e[30:0]} : 32'h0;
  endfunction

  function automatic bit model_fresh();
    return mmem[cidx][31] != ctog;
  endfunction

  // One request/write cycle plus the result check and one idle cycle.
  task automatic step(input string req, input bit wr, input logic [30:0] num,
                      input bit take, input bit peek);
    logic [31:0] exp;
    bit          asked;
    @(negedge clk);
    prod_wr  = wr;
    prod_num = num;
    req_take = take;
    req_peek = peek;
    asked = take || peek;
    exp = model_answer();
    if (take && model_fresh()) begin
      if (cidx == SLOTS - 1) ctog = ~ctog;
      cidx = (cidx + 1) % SLOTS;
      mcount--;
    end
    if (wr) begin
      mmem[pidx] = {pgen, num};
      if (pidx == SLOTS - 1) pgen = ~pgen;
      pidx = (pidx + 1) % SLOTS;
      mcount++;
    end
    @(negedge clk);
    prod_wr  = 1'b0;
    req_take = 1'b0;
    req_peek = 1'b0;
    check({req, " done"}, {31'h0, res_done}, {31'h0, asked});
    if (asked) check({req, " data"}, res_data, exp);
  endtask

  initial begin
    for (int i = 0; i < SLOTS; i++) mmem[i] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state.
    check("R1 reset done", {31'h0, res_done}, 32'h0);
    check("R1 reset data", res_data, 32'h0);
    step("R1 peek after reset", 1'b0, '0, 1'b0, 1'b1);
    step("R2 take on empty", 1'b0, '0, 1'b1, 1'b0);

    // Fill three entries, including the all-ones number.
    step("R9 write", 1'b1, 31'd5, 1'b0, 1'b0);
    step("R9 write", 1'b1, 31'h7FFF_FFFF, 1'b0, 1'b0);
    step("R9 write", 1'b1, 31'd0, 1'b0, 1'b0);
    step("R6 peek", 1'b0, '0, 1'b0, 1'b1);
    step("R6 peek again", 1'b0, '0, 1'b0, 1'b1);
    step("R3 take", 1'b0, '0, 1'b1, 1'b0);
    step("R8 take+peek", 1'b0, '0, 1'b1, 1'b1);   // R5: all-ones number
    step("R11 zero-number take", 1'b0, '0, 1'b1, 1'b0);
    step("R2 empty after drain", 1'b0, '0, 1'b1, 1'b0);

    // R10: write and take of the same slot in one cycle.
    step("R10 same-cycle", 1'b1, 31'd9, 1'b1, 1'b0);
    step("R10 later take", 1'b0, '0, 1'b1, 1'b0);

    // R7: hold take across the pending cycle; only one must be accepted.
    step("R7 write", 1'b1, 31'd21, 1'b0, 1'b0);
    step("R7 write", 1'b1, 31'd22, 1'b0, 1'b0);
    @(negedge clk);
    req_take = 1'b1;
    @(negedge clk);
    check("R7 held take done", {31'h0, res_done}, 32'h1);
    check("R7 held take data", res_data, 32'd21);
    if (cidx == SLOTS - 1) ctog = ~ctog;
    cidx = (cidx + 1) % SLOTS;
    mcount--;
    @(negedge clk);
    req_take = 1'b0;
    check("R7 ignored while busy", {31'h0, res_done}, 32'h0);
    step("R7 one advance only", 1'b0, '0, 1'b0, 1'b1);
    step("R7 drain", 1'b0, '0, 1'b1, 1'b0);

    // R4/R9: several full laps so both generation flags wrap.
    for (int lap = 0; lap < 3; lap++) begin
      for (int k = 0; k < SLOTS - 1; k++)
        step("R9 lap write", 1'b1, 31'(100 + lap * 32 + k), 1'b0, 1'b0);
      for (int k = 0; k < SLOTS - 1; k++)
        step("R4 lap take", 1'b0, '0, 1'b1, 1'b0);
      step("R4 stale lap reads empty", 1'b0, '0, 1'b0, 1'b1);
    end

    // Random mix of writes, takes and peeks, often in the same cycle.
    for (int n = 0; n < 600; n++) begin
      bit          w, t, p;
      logic [30:0] v;
      w = ($urandom_range(0, 2) != 0) && (mcount < SLOTS - 1);
      t = ($urandom_range(0, 2) == 0);
      p = ($urandom_range(0, 3) == 0);
      v = ($urandom_range(0, 7) == 0) ? 31'd0 : 31'($urandom);
      step("R2 R3 R6 R10 random", w, v, t, p);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule